// File: doc/BRIEF.md
# Configurable Instruction-Subset Processor Core

This block is a small multi-cycle processor for 32-bit instructions in the classic three-register / base-plus-offset layout. It executes only those instructions that were switched on by parameters when the block was built. The available instructions are a register add, a word load and a word store. Every other encoding, and every instruction that was switched off, runs as a short no-op that still moves the program counter on. Instructions and data live in two separate word-addressed memories that sit outside the core. Each memory has a synchronous read: the data arrives one clock after the address.

One instruction is in flight at a time. Every instruction begins with a fetch cycle and a decode cycle that reads the registers. An execute cycle then forms either the sum or the memory address, each on its own adder. Loads and stores use a memory cycle after that. Adds and loads finish with a write-back cycle. The program counter counts instruction words, so it steps by one. A one-cycle `retire` strobe marks the last cycle of every instruction, and the program counter is visible on a debug port.

Top module: `subset_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pc_dbg` and `imem_addr` are 0 and neither `dmem_re` nor `dmem_we` is asserted. Reset also clears every register to zero.
- R2: A word with bits [31:26] = 0x00 and bits [5:0] = 0x20 is an add. It writes reg[bits 25:21] + reg[bits 20:16] (modulo 2^32) into reg[bits 15:11] and takes 4 cycles, counted from fetch to retire.
- R3: A word with bits [31:26] = 0x23 is a load. It writes DM[address] into reg[bits 20:16] and takes 5 cycles. The address is the low DADDR_W bits of reg[bits 25:21] + imm. `dmem_re` is high for one cycle, and `retire` is high in the following cycle.
- R4: A word with bits [31:26] = 0x2b is a store. It writes reg[bits 20:16] to DM[address], with the address formed as in R3, and takes 4 cycles. `dmem_we` is high for exactly one cycle, and that cycle is the retire cycle.
- R5: Register 0 always reads as zero, and writes to it are dropped.
- R6: An instruction runs as a no-op that takes 3 cycles when its enable parameter is 0, or when it matches none of the encodings in R2 to R4 (including opcode 0x00 with any other function code). A no-op touches no register and no data memory.
- R7: `imem_addr` always equals `pc_dbg`. The program counter rises by exactly 1 in the cycle after each `retire` and holds its value at all other times.
- R8: The 16-bit immediate in bits [15:0] is sign-extended before the address add, so a negative offset reaches words below the base.
- R9: Instructions never overlap. `retire` lasts one cycle and is followed by at least two cycles without `retire`. The next fetch starts in the cycle right after `retire`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | IADDR_W | Instruction word index (the program counter) |
| imem_rdata | input | 32 | Instruction word, valid one cycle after `imem_addr` |
| dmem_addr | output | DADDR_W | Data word index for load or store |
| dmem_re | output | 1 | Data read strobe (load) |
| dmem_we | output | 1 | Data write strobe (store) |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data, valid one cycle after `dmem_re` |
| pc_dbg | output | IADDR_W | Debug copy of the program counter |
| retire | output | 1 | High in the last cycle of each instruction |

## Verification
A directed prologue comes first. It loads two operands and adds them, sends an add to register 0 and stores register 0, and then loads and stores through a base register with negative offsets. It also contains an unknown opcode, a type-0 word with a foreign function code and an all-zero word. This prologue separates correct decoding and sign extension from an off-by-field or zero-extension error. A long stretch of seeded random adds, loads and stores with random register fields and random immediates follows, ending with a dump of all 32 registers into data memory. The bench compares that memory image word by word with a reference model, and it checks the length of every instruction against the cycle counts for its kind. A second copy built with the add disabled shows that a switched-off add changes nothing: the stored result stays zero.

// File: rtl/subset_core_pkg.sv
// Package: shared encodings and types for the instruction-subset core.
// Assumes the fixed 32-bit instruction layout with 5-bit register fields.
package subset_core_pkg;

    localparam int INSTR_W   = 32;
    localparam int REG_IDX_W = 5;
    localparam int IMM_W     = 16;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] FN_ADD    = 6'h20;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2b;

    // Control sequence of one instruction.
    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEM    = 3'd3,
        ST_WB     = 3'd4
    } core_state_e;

    // Decoded class of an instruction after enable gating.
    typedef enum logic [1:0] {
        K_NOP   = 2'd0,
        K_ADD   = 2'd1,
        K_LOAD  = 2'd2,
        K_STORE = 2'd3
    } op_kind_e;

    // Field view of an instruction word.
    typedef struct packed {
        logic [5:0]           opcode;
        logic [REG_IDX_W-1:0] rs;
        logic [REG_IDX_W-1:0] rt;
        logic [REG_IDX_W-1:0] rd;
        logic [4:0]           shamt;
        logic [5:0]           funct;
    } instr_fields_t;

endpackage

// File: rtl/sc_decode.sv
// Module: sc_decode
// Classifies an instruction word into add / load / store / no-op and
// extracts its register indices and immediate. An instruction whose
// enable parameter is 0 is reported as a no-op. Purely combinational.
module sc_decode
    import subset_core_pkg::*;
#(
    parameter bit ENABLE_ADD   = 1'b1,
    parameter bit ENABLE_LOAD  = 1'b1,
    parameter bit ENABLE_STORE = 1'b1
) (
    input  logic [INSTR_W-1:0]   instr,
    output op_kind_e             kind,
    output logic [REG_IDX_W-1:0] rs_idx,
    output logic [REG_IDX_W-1:0] rt_idx,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic [IMM_W-1:0]     imm
);

    instr_fields_t f;
    logic hit_add;
    logic hit_load;
    logic hit_store;

    assign f      = instr_fields_t'(instr);
    assign rs_idx = f.rs;
    assign rt_idx = f.rt;
    assign rd_idx = f.rd;
    assign imm    = instr[IMM_W-1:0];

    // Per-instruction matchers; a disabled instruction never matches.
    generate
        if (ENABLE_ADD) begin : g_add_on
            assign hit_add = (f.opcode == OPC_RTYPE) && (f.funct == FN_ADD);
        end else begin : g_add_off
            assign hit_add = 1'b0;
        end
        if (ENABLE_LOAD) begin : g_load_on
            assign hit_load = (f.opcode == OPC_LOAD);
        end else begin : g_load_off
            assign hit_load = 1'b0;
        end
        if (ENABLE_STORE) begin : g_store_on
            assign hit_store = (f.opcode == OPC_STORE);
        end else begin : g_store_off
            assign hit_store = 1'b0;
        end
    endgenerate

    // Priority-free selection: the matchers are mutually exclusive by opcode.
    always_comb begin
        kind = K_NOP;
        if (hit_add)   kind = K_ADD;
        if (hit_load)  kind = K_LOAD;
        if (hit_store) kind = K_STORE;
    end

endmodule

// File: rtl/sc_regfile.sv
// Module: sc_regfile
// Flop-based register file with two combinational read ports and one
// synchronous write port. Entry 0 is hard-wired to zero and ignores writes.
// Assumes a synchronous active-low reset that clears every entry.
module sc_regfile #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [XLEN-1:0]  ra_data,
    output logic [XLEN-1:0]  rb_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data
);

    localparam int NREG = 1 << IDX_W;

    logic [XLEN-1:0] regs [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_entry
            if (i == 0) begin : g_zero
                assign regs[i] = '0;
            end else begin : g_flop
                // Holds one architectural register; loads on matching write.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        regs[i] <= '0;
                    end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                        regs[i] <= wr_data;
                    end
                end
            end
        end
    endgenerate

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

endmodule

// File: rtl/sc_exec.sv
// Module: sc_exec
// Execution units: a dedicated operand adder for the register add and a
// separate address adder that applies the sign-extended immediate.
// Both are combinational; the caller registers whichever result it needs.
module sc_exec #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  sum,
    output logic [XLEN-1:0]  ea
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_sext;

    assign imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign sum      = opnd_a + opnd_b;
    assign ea       = opnd_a + imm_sext;

endmodule

// File: rtl/subset_core.sv
// Module: subset_core (top)
// Multi-cycle core executing a parameter-selected subset of add / load /
// store. Sequence: FETCH -> DECODE -> EXEC -> [MEM] -> [WB]. No-ops retire
// in EXEC, stores in MEM, adds and loads in WB. The program counter is a
// word index that steps by one on every retire.
// Assumes both memories return read data one cycle after the address,
// and DADDR_W <= XLEN.
module subset_core
    import subset_core_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int IADDR_W      = 10,
    parameter int DADDR_W      = 10,
    parameter bit ENABLE_ADD   = 1'b1,
    parameter bit ENABLE_LOAD  = 1'b1,
    parameter bit ENABLE_STORE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [IADDR_W-1:0] imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic               dmem_re,
    output logic               dmem_we,
    output logic [XLEN-1:0]    dmem_wdata,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic [IADDR_W-1:0] pc_dbg,
    output logic               retire
);

    core_state_e          state_q, state_d;
    logic [IADDR_W-1:0]   pc_q;
    op_kind_e             kind_q;
    logic [REG_IDX_W-1:0] rt_q, rd_q;
    logic [IMM_W-1:0]     imm_q;
    logic [XLEN-1:0]      a_q, b_q, res_q;

    op_kind_e             dec_kind;
    logic [REG_IDX_W-1:0] dec_rs, dec_rt, dec_rd;
    logic [IMM_W-1:0]     dec_imm;
    logic [XLEN-1:0]      rf_a, rf_b;
    logic [XLEN-1:0]      ex_sum, ex_ea;
    logic                 rf_we;
    logic [REG_IDX_W-1:0] rf_widx;
    logic [XLEN-1:0]      rf_wdata;

    sc_decode #(
        .ENABLE_ADD   (ENABLE_ADD),
        .ENABLE_LOAD  (ENABLE_LOAD),
        .ENABLE_STORE (ENABLE_STORE)
    ) u_decode (
        .instr  (imem_rdata),
        .kind   (dec_kind),
        .rs_idx (dec_rs),
        .rt_idx (dec_rt),
        .rd_idx (dec_rd),
        .imm    (dec_imm)
    );

    sc_regfile #(
        .XLEN  (XLEN),
        .IDX_W (REG_IDX_W)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (dec_rs),
        .rb_idx  (dec_rt),
        .ra_data (rf_a),
        .rb_data (rf_b),
        .wr_en   (rf_we),
        .wr_idx  (rf_widx),
        .wr_data (rf_wdata)
    );

    sc_exec #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) u_exec (
        .opnd_a (a_q),
        .opnd_b (b_q),
        .imm    (imm_q),
        .sum    (ex_sum),
        .ea     (ex_ea)
    );

    // Retire marks the final cycle of the current instruction.
    always_comb begin
        retire = 1'b0;
        unique case (state_q)
            ST_EXEC: retire = (kind_q == K_NOP);
            ST_MEM:  retire = (kind_q == K_STORE);
            ST_WB:   retire = 1'b1;
            default: retire = 1'b0;
        endcase
    end

    // Next-state selection for the instruction sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC: begin
                unique case (kind_q)
                    K_NOP:   state_d = ST_FETCH;
                    K_ADD:   state_d = ST_WB;
                    default: state_d = ST_MEM;
                endcase
            end
            ST_MEM:    state_d = (kind_q == K_LOAD) ? ST_WB : ST_FETCH;
            ST_WB:     state_d = ST_FETCH;
            default:   state_d = ST_FETCH;
        endcase
    end

    // State register and program counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (retire) begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end

    // Decode-stage capture of instruction fields and register operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_NOP;
            rt_q   <= '0;
            rd_q   <= '0;
            imm_q  <= '0;
            a_q    <= '0;
            b_q    <= '0;
        end else if (state_q == ST_DECODE) begin
            kind_q <= dec_kind;
            rt_q   <= dec_rt;
            rd_q   <= dec_rd;
            imm_q  <= dec_imm;
            a_q    <= rf_a;
            b_q    <= rf_b;
        end
    end

    // Execute-stage capture of the sum or the effective address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (state_q == ST_EXEC) begin
            res_q <= (kind_q == K_ADD) ? ex_sum : ex_ea;
        end
    end

    // Write-back port selection: add writes rd, load writes rt.
    always_comb begin
        rf_we    = (state_q == ST_WB);
        rf_widx  = (kind_q == K_LOAD) ? rt_q : rd_q;
        rf_wdata = (kind_q == K_LOAD) ? dmem_rdata : res_q;
    end

    assign imem_addr  = pc_q;
    assign pc_dbg     = pc_q;
    assign dmem_addr  = res_q[DADDR_W-1:0];
    assign dmem_re    = (state_q == ST_MEM) && (kind_q == K_LOAD);
    assign dmem_we    = (state_q == ST_MEM) && (kind_q == K_STORE);
    assign dmem_wdata = b_q;

endmodule

// File: rtl/subset_core_chk.sv
// Module: subset_core_chk
// Port-level protocol checks for subset_core, attached by bind below.
// Assumes the synchronous active-low reset of the core.
module subset_core_chk #(
    parameter int IADDR_W      = 10,
    parameter bit ENABLE_STORE = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [IADDR_W-1:0] pc_dbg,
    input logic [IADDR_W-1:0] imem_addr,
    input logic               dmem_re,
    input logic               dmem_we,
    input logic               retire
);

    // R1: first cycle out of reset starts at word 0 with no data access.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pc_dbg == '0) && !dmem_re && !dmem_we);

    // R7: fetch address mirrors the program counter.
    assert_fetch_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr == pc_dbg);

    // R7: counter steps by one after each retire.
    assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> pc_dbg == $past(pc_dbg) + 1'b1);

    // R7: counter holds between retires.
    assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(pc_dbg));

    // R4: a store writes only in its retire cycle and never reads.
    assert_store_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> retire && !dmem_re);

    // R3: a load read is followed by the write-back retire.
    assert_load_then_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |=> retire && !dmem_re);

    // R9: at least two idle cycles follow every retire.
    assert_retire_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire ##1 !retire);

    // R6: a core built without stores never writes data memory.
    assert_no_disabled_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> ENABLE_STORE);

endmodule

bind subset_core subset_core_chk #(
    .IADDR_W      (IADDR_W),
    .ENABLE_STORE (ENABLE_STORE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_dbg    (pc_dbg),
    .imem_addr (imem_addr),
    .dmem_re   (dmem_re),
    .dmem_we   (dmem_we),
    .retire    (retire)
);

// File: tb/subset_core_test.sv
`timescale 1ns/1ps
module subset_core_test;

    localparam int IW        = 10;
    localparam int DW        = 10;
    localparam int IDEPTH    = 1 << IW;
    localparam int DDEPTH    = 1 << DW;
    localparam int DUMP_BASE = 960;
    localparam int N_RANDOM  = 150;
    localparam int LIMIT     = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // main core ports
    logic [IW-1:0] imem_addr, pc_dbg;
    logic [31:0]   imem_rdata, dmem_wdata, dmem_rdata;
    logic [DW-1:0] dmem_addr;
    logic          dmem_re, dmem_we, retire;

    // add-disabled core ports
    logic [3:0]  l_imem_addr, l_pc_dbg, l_dmem_addr;
    logic [31:0] l_imem_rdata, l_dmem_wdata, l_dmem_rdata;
    logic        l_dmem_re, l_dmem_we, l_retire;

    subset_core #(.XLEN(32), .IADDR_W(IW), .DADDR_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .pc_dbg(pc_dbg),
        .retire(retire));

    subset_core #(.XLEN(32), .IADDR_W(4), .DADDR_W(4), .ENABLE_ADD(1'b0)) uut_lite (
        .clk(clk), .rst_n(rst_n), .imem_addr(l_imem_addr), .imem_rdata(l_imem_rdata),
        .dmem_addr(l_dmem_addr), .dmem_re(l_dmem_re), .dmem_we(l_dmem_we),
        .dmem_wdata(l_dmem_wdata), .dmem_rdata(l_dmem_rdata), .pc_dbg(l_pc_dbg),
        .retire(l_retire));

    logic [31:0] imem [IDEPTH];
    logic [31:0] dmem [DDEPTH];
    logic [31:0] l_imem [16];
    logic [31:0] l_dmem [16];

    // synchronous-read memory models
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr];
        dmem_rdata <= dmem[dmem_addr];
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
        l_imem_rdata <= l_imem[l_imem_addr];
        l_dmem_rdata <= l_dmem[l_dmem_addr];
        if (l_dmem_we) l_dmem[l_dmem_addr] <= l_dmem_wdata;
    end

    // reference model state
    logic [31:0] mreg [32];
    logic [31:0] mdmem [DDEPTH];
    int prog_len = 0;
    int n_checks = 0;
    int n_fail   = 0;
    int nret     = 0;
    int cyc      = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_add(input int rs, input int rt, input int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                          input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // expected length of an instruction in cycles, from R2, R3, R4, R6
    function automatic int exp_cycles(input logic [31:0] w);
        if (w[31:26] == 6'h00 && w[5:0] == 6'h20) return 4;
        if (w[31:26] == 6'h23) return 5;
        if (w[31:26] == 6'h2b) return 4;
        return 3;
    endfunction

    function automatic string kind_tag(input logic [31:0] w);
        if (w[31:26] == 6'h00 && w[5:0] == 6'h20) return "R2 add length";
        if (w[31:26] == 6'h23) return "R3 load length";
        if (w[31:26] == 6'h2b) return "R4 store length";
        return "R6 no-op length";
    endfunction

    // reference execution of one instruction (R2..R6, R8)
    task automatic model_exec(input logic [31:0] w);
        logic [31:0] ea;
        ea = mreg[w[25:21]] + {{16{w[15]}}, w[15:0]};
        if (w[31:26] == 6'h00 && w[5:0] == 6'h20) begin
            if (w[15:11] != 0) mreg[w[15:11]] = mreg[w[25:21]] + mreg[w[20:16]];
        end else if (w[31:26] == 6'h23) begin
            if (w[20:16] != 0) mreg[w[20:16]] = mdmem[ea[DW-1:0]];
        end else if (w[31:26] == 6'h2b) begin
            mdmem[ea[DW-1:0]] = mreg[w[20:16]];
        end
    endtask

    task automatic emit(input logic [31:0] w);
        imem[prog_len] = w;
        model_exec(w);
        prog_len++;
    endtask

    // per-retire monitor: instruction length (R2-R4, R6, R9) and PC order (R7)
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0;
            nret = 0;
        end else begin
            cyc++;
            if (retire) begin
                check(cyc == exp_cycles(imem[pc_dbg]), kind_tag(imem[pc_dbg]),
                      "cycles", cyc, exp_cycles(imem[pc_dbg]));
                check(pc_dbg == IW'(nret), "R7", "pc at retire", 32'(pc_dbg), nret);
                nret++;
                cyc = 0;
            end
        end
    end

    initial begin
        logic [31:0] va, vb, w;
        int waited;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        for (int i = 0; i < IDEPTH; i++) imem[i] = '0;
        for (int i = 0; i < DDEPTH; i++) begin
            w = $urandom();
            dmem[i] <= w;
            mdmem[i] = w;
        end
        va = 32'h7fff_fff0;
        vb = 32'h0000_0123;
        dmem[4] <= va;  mdmem[4] = va;
        dmem[8] <= vb;  mdmem[8] = vb;
        dmem[40] <= 32'd48; mdmem[40] = 32'd48;

        // directed prologue
        emit(enc_i(6'h23, 0, 1, 16'd4));       // r1 = DM[4]
        emit(enc_i(6'h23, 0, 2, 16'd8));       // r2 = DM[8]
        emit(enc_add(1, 2, 3));                // r3 = r1 + r2 (R2)
        emit(enc_add(1, 2, 0));                // write to r0 dropped (R5)
        emit(enc_i(6'h2b, 0, 0, 16'd20));      // DM[20] = r0 (R5)
        emit(enc_i(6'h23, 0, 4, 16'd40));      // r4 = 48
        emit(enc_i(6'h23, 4, 5, 16'hfff8));    // r5 = DM[40] (R8)
        emit(enc_i(6'h2b, 4, 3, 16'hfffc));    // DM[44] = r3 (R8)
        emit(32'hfc00_0000 | 32'h0012_3456);   // unknown opcode (R6)
        emit(enc_add(1, 2, 6) ^ 32'h1);        // funct 0x21 (R6)
        emit(32'h0);                           // all-zero word (R6)

        // seeded random mix; random stores keep to words 128..959
        for (int k = 0; k < N_RANDOM; k++) begin
            case ($urandom_range(0, 3))
                0: emit(enc_add($urandom_range(0, 31), $urandom_range(0, 31),
                                $urandom_range(0, 31)));
                1: emit(enc_i(6'h23, $urandom_range(0, 31), $urandom_range(0, 31),
                              16'($urandom())));
                2: emit(enc_i(6'h2b, 0, $urandom_range(0, 31),
                              16'($urandom_range(128, DUMP_BASE - 1))));
                default: emit({6'($urandom_range(1, 34)), 26'($urandom())});
            endcase
        end
        for (int r = 0; r < 32; r++) emit(enc_i(6'h2b, 0, r, 16'(DUMP_BASE + r)));

        // add-disabled core program
        for (int i = 0; i < 16; i++) begin
            l_imem[i] = '0;
            l_dmem[i] <= '0;
        end
        l_dmem[5] <= 32'h0000_1234;
        l_dmem[6] <= 32'hdead_beef;
        l_imem[0] = enc_i(6'h23, 0, 1, 16'd5);   // r1 = 0x1234
        l_imem[1] = enc_add(1, 1, 2);            // disabled: r2 stays 0
        l_imem[2] = enc_i(6'h2b, 0, 2, 16'd6);   // DM[6] = r2
        l_imem[3] = enc_i(6'h2b, 0, 1, 16'd7);   // DM[7] = r1

        // reset phase (R1)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc_dbg == '0, "R1", "pc in reset", 32'(pc_dbg), 0);
        check(!dmem_we && !dmem_re, "R1", "strobes in reset", {dmem_we, dmem_re}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(imem_addr == '0, "R1", "first fetch address", 32'(imem_addr), 0);
        check(!dmem_we && !dmem_re, "R1", "strobes after reset", {dmem_we, dmem_re}, 0);

        waited = 0;
        while (nret < prog_len && waited < LIMIT) begin
            @(negedge clk);
            waited++;
        end
        check(waited < LIMIT, "R9", "watchdog: program completed", waited, LIMIT);
        repeat (3) @(negedge clk);

        // directed results
        check(dmem[20] == 32'h0, "R5", "store of r0", dmem[20], 0);
        check(dmem[44] == va + vb, "R8", "negative-offset store of sum", dmem[44], va + vb);
        check(dmem[DUMP_BASE] == 32'h0, "R5", "r0 dump", dmem[DUMP_BASE], 0);
        // register dump and whole memory image against the model
        for (int r = 1; r < 32; r++)
            check(dmem[DUMP_BASE + r] == mreg[r], "R2", $sformatf("reg %0d", r),
                  dmem[DUMP_BASE + r], mreg[r]);
        for (int a = 0; a < DDEPTH; a++)
            check(dmem[a] == mdmem[a], "R4", $sformatf("dmem word %0d", a),
                  dmem[a], mdmem[a]);

        // add-disabled core (R6) and its load path (R3)
        check(l_dmem[6] == 32'h0, "R6", "disabled add left r2 zero", l_dmem[6], 0);
        check(l_dmem[7] == 32'h0000_1234, "R3", "lite load then store", l_dmem[7], 32'h1234);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule